// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block owns the program counter of a 32-bit core whose control transfers carry one delay slot. Each cycle in which an instruction retires, decode presents that instruction's transfer kind, its 16-bit word offset, its 26-bit word index, its two register operands and its link destination. The block evaluates the transfer condition itself, forms the target and, when the transfer is taken, records the target as a pending redirect. The step that follows always advances sequentially, so the delay-slot instruction is fetched. The redirect is applied on the step that retires the delay-slot instruction.

Linking transfers raise a write enable for the register file in the same cycle as their retiring step. The value offered is the address just past the delay slot. Decode, the register file and instruction memory sit outside the block.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears any pending redirect, including one recorded just before the reset. The first step after reset moves the PC to 4.
- R2: `kind_i` codes are as follows. 0 is no transfer, 1 is equal, 2 is not-equal, 3 is rs >= 0, 4 is rs < 0, 5 is rs > 0 and 6 is rs <= 0. 7 is an index jump, 8 is an index jump with link, 9 is a register jump and 10 is a register jump with link. Codes 11 to 15 act as 0. A step with no pending redirect and no taken transfer moves the PC to PC+4.
- R3: A step that takes a transfer still moves the PC to PC+4, which is the delay slot. The next step loads the target and clears the pending redirect, so it is applied exactly once.
- R4: A conditional target is (PC+4) plus the 16-bit offset, sign-extended and shifted left by 2. Negative offsets go backwards, so offset 0xff94 at PC 0x200 lands at 0x54.
- R5: An index-jump target is the 26-bit index shifted left by 2, under the top four bits of the delay-slot address (PC+4). At PC 0xFFFFFFFC with index 3, the target is 0x0000000C.
- R6: A register-jump target (codes 9 and 10) is the full value of `rs_val_i`.
- R7: Conditions compare as two's-complement values. Code 1 is taken when rs == rt and code 2 when rs != rt. Codes 3 to 6 compare rs with zero. A transfer that is not taken records nothing.
- R8: On a step with code 8, `link_we_o` is 1, `link_dst_o` is 31 and `link_val_o` is PC+8, all in the same cycle.
- R9: On a step with code 10, `link_we_o` is 1, `link_dst_o` equals `rd_i` and `link_val_o` is PC+8. All other codes leave `link_we_o` at 0.
- R10: A transfer that retires in a delay slot, while a redirect is pending, is ignored. It does not link, and the sequence continues sequentially from the earlier target.
- R11: While `step_i` is 0, the PC and the pending redirect hold, and `link_we_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | The instruction at `pc_o` retires this cycle |
| kind_i | input | 4 | Transfer kind of the retiring instruction |
| offset_i | input | 16 | Conditional word offset |
| index_i | input | 26 | Index-jump word index |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| rd_i | input | 5 | Link destination for register jump with link |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Link write enable |
| link_dst_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Link value (PC+8) |

## Verification
The link outputs are combinational on the retiring step, so the bench samples them 1 ns after driving inputs at the falling edge, before the rising edge. `pc_o` updates at the rising edge on which the step is taken, and the bench samples it 1 ns after that edge. A taken transfer therefore shows PC+4 one edge after its step, and the target only one edge after the following step. Every vector checks both of those points: the delay-slot address first, then the final address.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int PC_W     = 32;
    localparam int OFF_W    = 16;
    localparam int IDX_W    = 26;
    localparam int REG_AW   = 5;
    localparam int INSN_B   = 4;
    localparam int BR_SHIFT = $clog2(INSN_B);
    localparam int TOP_W    = PC_W - IDX_W - BR_SHIFT;
    localparam logic [REG_AW-1:0] RA_REG = REG_AW'(31);

    typedef enum logic [3:0] {
        XF_NONE = 4'd0,
        XF_EQ   = 4'd1,
        XF_NE   = 4'd2,
        XF_GEZ  = 4'd3,
        XF_LTZ  = 4'd4,
        XF_GTZ  = 4'd5,
        XF_LEZ  = 4'd6,
        XF_JIX  = 4'd7,
        XF_JIXL = 4'd8,
        XF_JRG  = 4'd9,
        XF_JRGL = 4'd10
    } xfer_e;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] target;
    } redirect_t;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] dst;
        logic [PC_W-1:0]   val;
    } link_t;

    function automatic logic is_linking(input xfer_e k);
        return (k == XF_JIXL) || (k == XF_JRGL);
    endfunction

    function automatic logic [PC_W-1:0] sext_offset(input logic [OFF_W-1:0] off);
        logic [PC_W-1:0] ext;
        ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        return ext << BR_SHIFT;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  xfer_e           kind,
    input  logic [PC_W-1:0] rs_val,
    input  logic [PC_W-1:0] rt_val,
    output logic            taken
);

    logic rs_neg;
    logic rs_zero;

    always_comb begin
        rs_neg  = $signed(rs_val) < $signed(PC_W'(0));
        rs_zero = (rs_val == '0);
        unique case (kind)
            XF_EQ:   taken = (rs_val == rt_val);
            XF_NE:   taken = (rs_val != rt_val);
            XF_GEZ:  taken = !rs_neg;
            XF_LTZ:  taken = rs_neg;
            XF_GTZ:  taken = !rs_neg && !rs_zero;
            XF_LEZ:  taken = rs_neg || rs_zero;
            XF_JIX, XF_JIXL, XF_JRG, XF_JRGL: taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  xfer_e            kind,
    input  logic [PC_W-1:0]  pc_seq,
    input  logic [OFF_W-1:0] offset,
    input  logic [IDX_W-1:0] index,
    input  logic [PC_W-1:0]  rs_val,
    output logic [PC_W-1:0]  target
);

    logic [PC_W-1:0] br_tgt;
    logic [PC_W-1:0] ix_tgt;

    always_comb begin
        br_tgt = pc_seq + sext_offset(offset);
        ix_tgt = {pc_seq[PC_W-1 -: TOP_W], index, {BR_SHIFT{1'b0}}};
        unique case (kind)
            XF_JIX, XF_JIXL: target = ix_tgt;
            XF_JRG, XF_JRGL: target = rs_val;
            default:         target = br_tgt;
        endcase
    end

endmodule

// File: rtl/npc_link.sv
module npc_link
    import npc_pkg::*;
(
    input  xfer_e             kind,
    input  logic              accept,
    input  logic [PC_W-1:0]   pc,
    input  logic [REG_AW-1:0] rd,
    output link_t             link
);

    localparam logic [PC_W-1:0] PAST_SLOT = PC_W'(2 * INSN_B);

    always_comb begin
        link.we  = accept && is_linking(kind);
        link.dst = (kind == XF_JIXL) ? RA_REG : rd;
        link.val = pc + PAST_SLOT;
    end

endmodule

// File: rtl/npc_seq.sv
module npc_seq
    import npc_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            take,
    input  logic [PC_W-1:0] target,
    input  logic [PC_W-1:0] pc_seq,
    output logic [PC_W-1:0] pc_q,
    output logic            pend
);

    redirect_t redir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            redir_q <= '0;
        end else if (step) begin
            if (redir_q.valid) begin
                pc_q          <= redir_q.target;
                redir_q.valid <= 1'b0;
            end else begin
                pc_q <= pc_seq;
                if (take) begin
                    redir_q.valid  <= 1'b1;
                    redir_q.target <= target;
                end
            end
        end
    end

    assign pend = redir_q.valid;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_i,
    input  logic [3:0]  kind_i,
    input  logic [15:0] offset_i,
    input  logic [25:0] index_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    input  logic [4:0]  rd_i,
    output logic [31:0] pc_o,
    output logic        link_we_o,
    output logic [4:0]  link_dst_o,
    output logic [31:0] link_val_o
);

    xfer_e           kind_w;
    logic            taken_w;
    logic            pend_w;
    logic            accept_w;
    logic [PC_W-1:0] pc_w;
    logic [PC_W-1:0] pc_seq_w;
    logic [PC_W-1:0] target_w;
    link_t           link_w;

    assign kind_w   = xfer_e'(kind_i);
    assign accept_w = step_i && !pend_w;
    assign pc_seq_w = pc_w + PC_W'(INSN_B);

    npc_cond cond_i (
        .kind   (kind_w),
        .rs_val (rs_val_i),
        .rt_val (rt_val_i),
        .taken  (taken_w)
    );

    npc_target target_i (
        .kind   (kind_w),
        .pc_seq (pc_seq_w),
        .offset (offset_i),
        .index  (index_i),
        .rs_val (rs_val_i),
        .target (target_w)
    );

    npc_seq #(.RESET_PC(RESET_PC)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .step   (step_i),
        .take   (accept_w && taken_w),
        .target (target_w),
        .pc_seq (pc_seq_w),
        .pc_q   (pc_w),
        .pend   (pend_w)
    );

    npc_link link_i (
        .kind   (kind_w),
        .accept (accept_w),
        .pc     (pc_w),
        .rd     (rd_i),
        .link   (link_w)
    );

    assign pc_o       = pc_w;
    assign link_we_o  = link_w.we;
    assign link_dst_o = link_w.dst;
    assign link_val_o = link_w.val;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input logic        clk,
    input logic        rst,
    input logic        step_i,
    input logic [3:0]  kind_i,
    input logic [31:0] pc_o,
    input logic        link_we_o,
    input logic [4:0]  link_dst_o,
    input logic        pend
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC) && !pend);

    a_r11_hold_pc: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(pc_o));

    a_r11_hold_pend: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(pend));

    a_r11_no_link_idle: assert property (@(posedge clk) disable iff (rst)
        !step_i |-> !link_we_o);

    a_r3_slot_advance: assert property (@(posedge clk) disable iff (rst)
        (step_i && !pend) |=> (pc_o == $past(pc_o) + 32'd4));

    a_r3_apply_once: assert property (@(posedge clk) disable iff (rst)
        (step_i && pend) |=> !pend);

    a_r10_no_link_in_slot: assert property (@(posedge clk) disable iff (rst)
        pend |-> !link_we_o);

    a_r8_ra_dest: assert property (@(posedge clk) disable iff (rst)
        (link_we_o && kind_i == 4'd8) |-> (link_dst_o == 5'd31));

    a_r9_plain_no_link: assert property (@(posedge clk) disable iff (rst)
        (kind_i != 4'd8 && kind_i != 4'd10) |-> !link_we_o);

endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .kind_i     (kind_i),
    .pc_o       (pc_o),
    .link_we_o  (link_we_o),
    .link_dst_o (link_dst_o),
    .pend       (pend_w)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;

    typedef struct packed {
        logic [3:0]  kind;
        logic [31:0] start;
        logic [15:0] off;
        logic [25:0] idx;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [4:0]  rd;
        logic [31:0] exp_pc;
        logic        exp_we;
        logic [4:0]  exp_dst;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  32'h200,      16'hff94, 26'h0,  32'h2,        32'h2, 5'd0, 32'h54,       1'b0, 5'd0},
        '{4'd1,  32'h200,      16'hff94, 26'h0,  32'h2,        32'h3, 5'd0, 32'h208,      1'b0, 5'd0},
        '{4'd2,  32'h100,      16'h0010, 26'h0,  32'h1,        32'h2, 5'd0, 32'h144,      1'b0, 5'd0},
        '{4'd3,  32'h300,      16'h0004, 26'h0,  32'h0,        32'h0, 5'd0, 32'h314,      1'b0, 5'd0},
        '{4'd3,  32'h300,      16'h0004, 26'h0,  32'h80000000, 32'h0, 5'd0, 32'h308,      1'b0, 5'd0},
        '{4'd4,  32'h300,      16'h0002, 26'h0,  32'hffffffff, 32'h0, 5'd0, 32'h30c,      1'b0, 5'd0},
        '{4'd5,  32'h300,      16'h0002, 26'h0,  32'h0,        32'h0, 5'd0, 32'h308,      1'b0, 5'd0},
        '{4'd6,  32'h300,      16'hfffe, 26'h0,  32'h0,        32'h0, 5'd0, 32'h2fc,      1'b0, 5'd0},
        '{4'd7,  32'h10000000, 16'h0,    26'h24, 32'h0,        32'h0, 5'd0, 32'h10000090, 1'b0, 5'd0},
        '{4'd8,  32'h4,        16'h0,    26'h10, 32'h0,        32'h0, 5'd0, 32'h40,       1'b1, 5'd31},
        '{4'd9,  32'h40,       16'h0,    26'h0,  32'h1234,     32'h0, 5'd0, 32'h1234,     1'b0, 5'd0},
        '{4'd10, 32'h40,       16'h0,    26'h0,  32'h800,      32'h0, 5'd7, 32'h800,      1'b1, 5'd7},
        '{4'd7,  32'hfffffffc, 16'h0,    26'h3,  32'h0,        32'h0, 5'd0, 32'hc,        1'b0, 5'd0},
        '{4'd0,  32'h500,      16'h0,    26'h0,  32'h0,        32'h0, 5'd0, 32'h508,      1'b0, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0;
    logic [3:0]  kind_i = '0;
    logic [15:0] offset_i = '0;
    logic [25:0] index_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [4:0]  rd_i = '0;
    logic [31:0] pc_o;
    logic        link_we_o;
    logic [4:0]  link_dst_o;
    logic [31:0] link_val_o;

    int checks = 0;
    int failures = 0;
    logic        cap_we;
    logic [4:0]  cap_dst;
    logic [31:0] cap_val;

    always #5 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst(rst), .step_i(step_i), .kind_i(kind_i),
        .offset_i(offset_i), .index_i(index_i), .rs_val_i(rs_val_i),
        .rt_val_i(rt_val_i), .rd_i(rd_i), .pc_o(pc_o),
        .link_we_o(link_we_o), .link_dst_o(link_dst_o), .link_val_o(link_val_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] k, input logic [15:0] off, input logic [25:0] idx,
                         input logic [31:0] rs, input logic [31:0] rt, input logic [4:0] rd);
        @(negedge clk);
        kind_i = k; offset_i = off; index_i = idx;
        rs_val_i = rs; rt_val_i = rt; rd_i = rd; step_i = 1'b1;
        #1;
        cap_we = link_we_o; cap_dst = link_dst_o; cap_val = link_val_o;
        @(posedge clk);
        #1;
        step_i = 1'b0; kind_i = '0;
    endtask

    task automatic set_pc(input logic [31:0] p);
        apply(4'd9, '0, '0, p, '0, '0);
        apply(4'd0, '0, '0, '0, '0, '0);
    endtask

    function automatic string tag_of(input logic [3:0] k);
        if (k >= 4'd1 && k <= 4'd6) return "R4 R7";
        if (k == 4'd7 || k == 4'd8) return "R5";
        if (k == 4'd9 || k == 4'd10) return "R6";
        return "R2";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pc", pc_o, 32'h0);
        check("R11 reset no link", {31'b0, link_we_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        apply(4'd0, '0, '0, '0, '0, '0);
        check("R1 R2 first step", pc_o, 32'h4);

        for (int i = 0; i < NV; i++) begin
            set_pc(VEC[i].start);
            apply(VEC[i].kind, VEC[i].off, VEC[i].idx, VEC[i].rs, VEC[i].rt, VEC[i].rd);
            if (VEC[i].kind == 4'd8) check("R8 link we", {31'b0, cap_we}, {31'b0, VEC[i].exp_we});
            else                     check("R9 link we", {31'b0, cap_we}, {31'b0, VEC[i].exp_we});
            if (VEC[i].exp_we) begin
                check("R8 R9 link dst", {27'b0, cap_dst}, {27'b0, VEC[i].exp_dst});
                check("R8 R9 link val", cap_val, VEC[i].start + 32'd8);
            end
            check("R3 delay slot pc", pc_o, VEC[i].start + 32'd4);
            apply(4'd0, '0, '0, '0, '0, '0);
            check(tag_of(VEC[i].kind), pc_o, VEC[i].exp_pc);
        end

        // R11: idle cycles hold pc and pending redirect
        set_pc(32'h600);
        apply(4'd8, '0, 26'h100, '0, '0, '0);
        @(negedge clk);
        kind_i = 4'd1;
        rs_val_i = 32'h5; rt_val_i = 32'h5;
        #1;
        check("R11 idle no link", {31'b0, link_we_o}, 32'h0);
        repeat (3) @(posedge clk);
        #1;
        check("R11 idle hold pc", pc_o, 32'h604);
        kind_i = '0;
        apply(4'd0, '0, '0, '0, '0, '0);
        check("R11 pending kept", pc_o, 32'h400);

        // R10: transfer in the delay slot is ignored
        set_pc(32'h700);
        apply(4'd1, 16'h0008, '0, 32'h5, 32'h5, '0);
        apply(4'd8, '0, 26'h3, '0, '0, '0);
        check("R10 slot no link", {31'b0, cap_we}, 32'h0);
        check("R10 first target", pc_o, 32'h724);
        apply(4'd0, '0, '0, '0, '0, '0);
        check("R10 no second redirect", pc_o, 32'h728);

        // R1: reset clears a pending redirect
        set_pc(32'h800);
        apply(4'd7, '0, 26'h50, '0, '0, '0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset mid pending", pc_o, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        apply(4'd0, '0, '0, '0, '0, '0);
        check("R1 pending cleared", pc_o, 32'h4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule